// File: doc/BRIEF.md
# Bit-Masked Write Control Register Bank

This block is a small memory-mapped register file that holds the control bits for a storage-interface PHY and reports two of its status flags. Software reaches it over a simple synchronous bus: an address, a write strobe with a 32-bit write word, a read strobe, and a registered read word. Each of the seven control registers keeps 16 stored bits, and their contents drive output ports directly.

A write never needs a read-modify-write. The upper half of every written word is a per-bit enable for the lower half. A stored bit takes the new value only when its enable is 1. Any other stored bit keeps its value. Two bits of the last control register switch the PHY on and enable its delay-locked loop. A read-only status word reports whether calibration has finished and whether the delay-locked loop is locked.

Top module: `hwmask_regbank`

## Requirements
- R1: During reset and in the cycle after it, every control bit is 0, `phy_pwr_on_o` and `phy_dll_en_o` are 0, and `bus_rdata` is 0.
- R2: On a write to a control register, stored bit x (0..15) takes `bus_wdata[x]` if `bus_wdata[x+16]` is 1 and otherwise keeps its value. The new value is visible on `ctrl_o` in the cycle after the strobe.
- R3: Control register k (k = 0..6) sits at byte address 4*k (0x00 to 0x18), and its 16 stored bits appear on `ctrl_o[16*k+15:16*k]`.
- R4: Bit 0 of the register at 0x18 drives `phy_pwr_on_o` (1 = powered). Bit 1 of that register drives `phy_dll_en_o` (1 = enabled).
- R5: A read of address 0x20 returns `cal_done_i` in bit 6, `dll_lock_i` in bit 5, and 0 in every other bit. A write to 0x20 changes no control bit.
- R6: A read of a control register returns its 16 stored bits in bits 15..0, and 0 in bits 31..16.
- R7: Every address that is not listed above is unmapped. This covers 0x1C, 0x24 to 0xFF, and any address that is not a multiple of 4. A read of an unmapped address returns 0. A write to one changes no control bit.
- R8: `bus_rdata` is loaded only at the clock edge that samples `bus_rd` high, and is valid from the following cycle. In cycles without a read strobe it holds its value.
- R9: When a read and a write to the same control register arrive in the same cycle, the read returns the value from before the write. The next read returns the updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word: bits 31..16 are the per-bit enables, bits 15..0 are the values |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read word |
| cal_done_i | input | 1 | Calibration-finished flag from the PHY |
| dll_lock_i | input | 1 | Delay-locked-loop-locked flag from the PHY |
| ctrl_o | output | 112 | Stored bits of the seven control registers, register k at bits 16k+15..16k |
| phy_pwr_on_o | output | 1 | PHY power on (register 0x18 bit 0) |
| phy_dll_en_o | output | 1 | Delay-locked loop enable (register 0x18 bit 1) |

## Verification
A masked write and a read of the same control register can fall in the same cycle. The bench provokes this by raising both strobes together on address 0x04, with a word whose enables clear every bit. It judges the result by requiring the pre-write contents in that read and zero in the read that follows. Status sampling can also coincide with a write aimed at the status address. In that case the bench requires the read word to follow the flag inputs while every control bit on `ctrl_o` stays unchanged.

// File: rtl/hwmask_pkg.sv
package hwmask_pkg;
    localparam int unsigned HALF_W   = 16;
    localparam int unsigned WORD_W   = 2 * HALF_W;
    localparam int unsigned N_CTRL   = 7;
    localparam int unsigned BUS_AW   = 8;
    localparam int unsigned STAT_OFS = 32'h20;
    localparam int unsigned PWR_BIT  = 0;
    localparam int unsigned DLL_BIT  = 1;
    localparam int unsigned CAL_POS  = 6;
    localparam int unsigned LOCK_POS = 5;

    // What a decoded address selects for readback
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CTRL = 2'd1,
        RD_STAT = 2'd2
    } rd_kind_e;

    // Assemble the read-only status word from the PHY flags
    function automatic logic [WORD_W-1:0] status_word(input logic cal, input logic lock);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[CAL_POS]  = cal;
        w[LOCK_POS] = lock;
        return w;
    endfunction
endpackage

// File: rtl/hwmask_decode.sv
module hwmask_decode
    import hwmask_pkg::*;
#(
    parameter int unsigned N_REG  = 7,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  ctrl_sel,
    output rd_kind_e          kind,
    output logic [IDX_W-1:0]  idx
);
    // Exact word-aligned match per control register
    for (genvar k = 0; k < N_REG; k++) begin : g_sel
        assign ctrl_sel[k] = (addr == ADDR_W'(4 * k));
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < N_REG; k++) begin
            if (ctrl_sel[k]) idx = IDX_W'(k);
        end
        if (|ctrl_sel)                       kind = RD_CTRL;
        else if (addr == ADDR_W'(STAT_OFS))  kind = RD_STAT;
        else                                 kind = RD_NONE;
    end
endmodule

// File: rtl/hwmask_cell.sv
module hwmask_cell #(
    parameter int unsigned HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [2*HW-1:0] word,
    output logic [HW-1:0] q
);
    logic [HW-1:0] en;
    logic [HW-1:0] merged;

    assign en     = word[2*HW-1:HW];
    assign merged = (q & ~en) | (word[HW-1:0] & en);

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr_hit) q <= merged;
    end

    // R2
    hold_unsel_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(q));
    // R2
    masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (((q ^ $past(q)) & ~$past(en)) == '0));
    // R2
    enabled_take_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> ((q & $past(en)) == ($past(word[HW-1:0]) & $past(en))));
endmodule

// File: rtl/hwmask_rdmux.sv
module hwmask_rdmux
    import hwmask_pkg::*;
#(
    parameter int unsigned N_REG = 7,
    parameter int unsigned IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  rd_kind_e                kind,
    input  logic [IDX_W-1:0]        idx,
    input  logic [N_REG*HALF_W-1:0] ctrl_flat,
    input  logic                    cal,
    input  logic                    lock,
    output logic [WORD_W-1:0]       rd_data
);
    logic [HALF_W-1:0] sel_half;
    logic [WORD_W-1:0] nxt;

    always_comb begin
        sel_half = '0;
        for (int k = 0; k < N_REG; k++) begin
            if (idx == IDX_W'(k)) sel_half = ctrl_flat[k*HALF_W +: HALF_W];
        end
        case (kind)
            RD_CTRL: nxt = {{HALF_W{1'b0}}, sel_half};
            RD_STAT: nxt = status_word(cal, lock);
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= nxt;
    end

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    // R6
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && kind == RD_CTRL) |=> (rd_data[WORD_W-1:HALF_W] == '0));
    // R5
    stat_map_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && kind == RD_STAT) |=> (rd_data[CAL_POS] == $past(cal)
            && rd_data[LOCK_POS] == $past(lock)
            && $countones(rd_data) == (int'($past(cal)) + int'($past(lock)))));
    // R7
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && kind == RD_NONE) |=> (rd_data == '0));
endmodule

// File: rtl/hwmask_regbank.sv
module hwmask_regbank
    import hwmask_pkg::*;
#(
    parameter int unsigned N_REG  = N_CTRL,
    parameter int unsigned ADDR_W = BUS_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic                    bus_rd,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic                    cal_done_i,
    input  logic                    dll_lock_i,
    output logic [N_REG*HALF_W-1:0] ctrl_o,
    output logic                    phy_pwr_on_o,
    output logic                    phy_dll_en_o
);
    localparam int unsigned IDX_W   = (N_REG > 1) ? $clog2(N_REG) : 1;
    localparam int unsigned PHY_REG = N_REG - 1;

    logic [N_REG-1:0] ctrl_sel;
    rd_kind_e         kind;
    logic [IDX_W-1:0] idx;

    hwmask_decode #(.N_REG(N_REG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
        .addr     (bus_addr),
        .ctrl_sel (ctrl_sel),
        .kind     (kind),
        .idx      (idx)
    );

    for (genvar k = 0; k < N_REG; k++) begin : g_cell
        hwmask_cell #(.HW(HALF_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (bus_wr & ctrl_sel[k]),
            .word   (bus_wdata),
            .q      (ctrl_o[k*HALF_W +: HALF_W])
        );
    end

    hwmask_rdmux #(.N_REG(N_REG), .IDX_W(IDX_W)) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (bus_rd),
        .kind      (kind),
        .idx       (idx),
        .ctrl_flat (ctrl_o),
        .cal       (cal_done_i),
        .lock      (dll_lock_i),
        .rd_data   (bus_rdata)
    );

    assign phy_pwr_on_o = ctrl_o[PHY_REG*HALF_W + PWR_BIT];
    assign phy_dll_en_o = ctrl_o[PHY_REG*HALF_W + DLL_BIT];

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl_sel));
    // R7
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == RD_NONE) |=> $stable(ctrl_o));
    // R5
    stat_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == RD_STAT) |=> $stable(ctrl_o));
endmodule

// File: tb/hwmask_regbank_bench.sv
`timescale 1ns/1ps
module hwmask_regbank_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         cal_done_i = 1'b0;
    logic         dll_lock_i = 1'b0;
    logic [111:0] ctrl_o;
    logic         phy_pwr_on_o;
    logic         phy_dll_en_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hwmask_regbank u_hwmask_regbank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cal_done_i(cal_done_i), .dll_lock_i(dll_lock_i), .ctrl_o(ctrl_o),
        .phy_pwr_on_o(phy_pwr_on_o), .phy_dll_en_o(phy_dll_en_o)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
    } vec_t;

    // Write then read back; expected values follow the enable-merge rule
    localparam vec_t VEC [12] = '{
        '{8'h00, 32'hFFFF_A5A5, 32'h0000_A5A5},
        '{8'h00, 32'h00F0_FFFF, 32'h0000_A5F5},
        '{8'h04, 32'h1234_FFFF, 32'h0000_1234},
        '{8'h08, 32'h0000_FFFF, 32'h0000_0000},
        '{8'h0C, 32'h8001_8001, 32'h0000_8001},
        '{8'h10, 32'hFFFF_BEEF, 32'h0000_BEEF},
        '{8'h10, 32'hF000_0000, 32'h0000_0EEF},
        '{8'h14, 32'h0F0F_FFFF, 32'h0000_0F0F},
        '{8'h18, 32'h0003_0001, 32'h0000_0001},
        '{8'h18, 32'h0002_0002, 32'h0000_0003},
        '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h20, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, capture edge, release at next falling edge
    task automatic bus_op(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    endtask

    function automatic logic [15:0] reg_of(input int k);
        return ctrl_o[k*16 +: 16];
    endfunction

    logic [111:0] snap;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl in reset", 128'(ctrl_o), 128'(0));
        chk("R1 rdata in reset", 128'(bus_rdata), 128'(0));
        chk("R1 pwr/dll in reset", 128'({phy_pwr_on_o, phy_dll_en_o}), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ctrl after reset", 128'(ctrl_o), 128'(0));

        // R2 R3 R6 R7 R5: table walk
        for (int i = 0; i < 12; i++) begin
            bus_op(1'b1, 1'b0, VEC[i].addr, VEC[i].wdata);
            bus_op(1'b0, 1'b1, VEC[i].addr, 32'h0);
            chk($sformatf("R2/R6 vector %0d readback", i), 128'(bus_rdata), 128'(VEC[i].exp_rd));
        end

        // R3 field positions on ctrl_o
        chk("R3 reg0 field", 128'(reg_of(0)), 128'(16'hA5F5));
        chk("R3 reg1 field", 128'(reg_of(1)), 128'(16'h1234));
        chk("R3 reg3 field", 128'(reg_of(3)), 128'(16'h8001));
        chk("R3 reg4 field", 128'(reg_of(4)), 128'(16'h0EEF));
        chk("R3 reg5 field", 128'(reg_of(5)), 128'(16'h0F0F));
        // R4 power and DLL bits
        chk("R4 pwr on", 128'(phy_pwr_on_o), 128'(1));
        chk("R4 dll on", 128'(phy_dll_en_o), 128'(1));
        bus_op(1'b1, 1'b0, 8'h18, 32'h0001_0000);
        chk("R4 pwr cleared", 128'(phy_pwr_on_o), 128'(0));
        chk("R4 dll kept", 128'(phy_dll_en_o), 128'(1));
        chk("R2 reg6 after masked clear", 128'(reg_of(6)), 128'(16'h0002));

        // R5 status bit positions: cal -> bit 6, lock -> bit 5
        cal_done_i = 1'b1; dll_lock_i = 1'b0;
        bus_op(1'b0, 1'b1, 8'h20, 32'h0);
        chk("R5 status cal only", 128'(bus_rdata), 128'(32'h40));
        cal_done_i = 1'b0; dll_lock_i = 1'b1;
        bus_op(1'b0, 1'b1, 8'h20, 32'h0);
        chk("R5 status lock only", 128'(bus_rdata), 128'(32'h20));
        // R5 write to status coinciding with status read
        cal_done_i = 1'b1;
        snap = ctrl_o;
        bus_op(1'b1, 1'b1, 8'h20, 32'hFFFF_FFFF);
        chk("R5 status both", 128'(bus_rdata), 128'(32'h60));
        chk("R5 status write ignored", 128'(ctrl_o), 128'(snap));

        // R7 unmapped addresses
        bus_op(1'b0, 1'b1, 8'h24, 32'h0);
        chk("R7 read 0x24", 128'(bus_rdata), 128'(0));
        bus_op(1'b0, 1'b1, 8'h04, 32'h0);
        bus_op(1'b0, 1'b1, 8'hFC, 32'h0);
        chk("R7 read 0xFC", 128'(bus_rdata), 128'(0));
        bus_op(1'b0, 1'b1, 8'h04, 32'h0);
        bus_op(1'b0, 1'b1, 8'h01, 32'h0);
        chk("R7 read misaligned 0x01", 128'(bus_rdata), 128'(0));
        snap = ctrl_o;
        bus_op(1'b1, 1'b0, 8'h02, 32'hFFFF_FFFF);
        bus_op(1'b1, 1'b0, 8'h1C, 32'hFFFF_FFFF);
        bus_op(1'b1, 1'b0, 8'h80, 32'hFFFF_FFFF);
        chk("R7 unmapped writes ignored", 128'(ctrl_o), 128'(snap));

        // R8 hold without read strobe
        bus_op(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R8 read reg0", 128'(bus_rdata), 128'(32'hA5F5));
        bus_op(1'b1, 1'b0, 8'h00, 32'hFFFF_0000);
        repeat (3) @(negedge clk);
        chk("R8 rdata held", 128'(bus_rdata), 128'(32'hA5F5));
        chk("R2 reg0 cleared", 128'(reg_of(0)), 128'(16'h0000));

        // R9 read and write same register, same cycle
        bus_op(1'b1, 1'b1, 8'h04, 32'hFFFF_0000);
        chk("R9 read sees old value", 128'(bus_rdata), 128'(32'h1234));
        bus_op(1'b0, 1'b1, 8'h04, 32'h0);
        chk("R9 next read sees new value", 128'(bus_rdata), 128'(0));

        // R1 reset in mid-run
        bus_op(1'b0, 1'b1, 8'h14, 32'h0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 ctrl after late reset", 128'(ctrl_o), 128'(0));
        chk("R1 rdata after late reset", 128'(bus_rdata), 128'(0));
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule